// File: doc/BRIEF.md
# Sub-Element Dot-Product Accumulate Lane

This block is one lane of a vector integer multiply-accumulate datapath, working on a single 32-bit destination element. It splits each of the two 32-bit source elements into one, two or four equal sub-elements. It multiplies each sub-element of the first source by the sub-element in the same position of the second source. It then adds all of those products, and the old destination value, into a 32-bit result. The sum stays at full element width, and only the multiplies narrow.

A per-element select chooses whether sub-elements are read as two's-complement or unsigned values. A mask-enable input and a per-element mask bit together decide whether the element is updated or passed through unchanged. The lane takes one element per cycle and returns the result exactly two cycles later, flagged by a valid output. A wider vector unit places one lane per element slot and runs the slots in parallel.

Top module: `dp_lane`

## Requirements
- R1: With split code 2'b00 (one sub-element), out_acc = in_acc + in_src_a * in_src_b, keeping the low 32 bits; the signed select does not change this result.
- R2: With split code 2'b01 (two 16-bit sub-elements), out_acc = in_acc + a[31:16]*b[31:16] + a[15:0]*b[15:0].
- R3: With split code 2'b10 (four 8-bit sub-elements), out_acc = in_acc plus the sum of the four products of bytes in matching positions.
- R4: With in_signed = 1, each sub-element is read as a two's-complement value; with in_signed = 0, each is zero-extended.
- R5: All additions wrap modulo 2^32, with no saturation and no flag.
- R6: When in_vm = 0 and in_mask = 0, out_acc equals in_acc unchanged. When in_vm = 1, in_mask is ignored and the element is updated. When in_vm = 0 and in_mask = 1, the element is updated.
- R7: out_valid is high exactly two rising edges after an edge that samples in_valid high. One new element is accepted on every cycle. out_acc holds its value while no result arrives.
- R8: While reset is asserted, and until the first accepted element comes through, out_valid is low. A reset clears any element in flight.
- R9: The reserved split code 2'b11 behaves as split code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An element is presented this cycle |
| in_src_a | input | 32 | First source element |
| in_src_b | input | 32 | Second source element |
| in_acc | input | 32 | Old destination element |
| in_ediv | input | 2 | Split code: 00 one, 01 two, 10 four, 11 as 00 |
| in_signed | input | 1 | 1 reads sub-elements as signed, 0 as unsigned |
| in_vm | input | 1 | 1 updates the element regardless of the mask bit |
| in_mask | input | 1 | Per-element mask bit, used when in_vm is 0 |
| out_valid | output | 1 | out_acc carries a new result |
| out_acc | output | 32 | New destination element |

## Verification
The bench builds the lane with its default parameters: a 32-bit element and all three split widths generated. Every split code, including the reserved one, can therefore be driven and checked at the ports. Its vectors cover sign-extension cases that give different results in signed and unsigned modes, as well as sums that wrap past 2^32. Elements are streamed back to back so that pipeline overlap is exercised. Directed steps then cover the reset state, single-element latency and a reset that lands while an element is in flight.

// File: rtl/dp_pkg.sv
package dp_pkg;

  // Split code carried with each element
  typedef enum logic [1:0] {
    SPLIT_ONE  = 2'b00,
    SPLIT_TWO  = 2'b01,
    SPLIT_FOUR = 2'b10,
    SPLIT_RSVD = 2'b11
  } split_e;

  // Map a split code to the index of the generated dot unit (0:1, 1:2, 2:4)
  function automatic logic [1:0] split_index(input logic [1:0] code);
    logic [1:0] idx;
    case (split_e'(code))
      SPLIT_TWO:  idx = 2'd1;
      SPLIT_FOUR: idx = 2'd2;
      default:    idx = 2'd0;  // R9: reserved code handled as one sub-element
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dp_split_dot.sv
module dp_split_dot #(
  parameter int ELEM_W = 32,
  parameter int NSUB   = 2
) (
  input  logic              is_signed,
  input  logic [ELEM_W-1:0] src_a,
  input  logic [ELEM_W-1:0] src_b,
  output logic [ELEM_W-1:0] dot
);

  localparam int SUB_W = ELEM_W / NSUB;

  logic [NSUB-1:0][ELEM_W-1:0] prod;

  // Each sub-element is widened to the full element width; the product
  // taken modulo 2^ELEM_W equals the low bits of the exact product.
  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    logic [SUB_W-1:0]  sa;
    logic [SUB_W-1:0]  sb;
    logic [ELEM_W-1:0] wa;
    logic [ELEM_W-1:0] wb;

    assign sa = src_a[g*SUB_W +: SUB_W];
    assign sb = src_b[g*SUB_W +: SUB_W];

    if (SUB_W == ELEM_W) begin : g_full
      assign wa = sa;
      assign wb = sb;
    end else begin : g_ext
      assign wa = {{(ELEM_W-SUB_W){is_signed & sa[SUB_W-1]}}, sa};
      assign wb = {{(ELEM_W-SUB_W){is_signed & sb[SUB_W-1]}}, sb};
    end

    assign prod[g] = wa * wb;
  end

  always_comb begin
    dot = '0;
    for (int k = 0; k < NSUB; k++) begin
      dot = dot + prod[k];
    end
  end

endmodule

// File: rtl/dp_prod_stage.sv
module dp_prod_stage
  import dp_pkg::*;
#(
  parameter int ELEM_W    = 32,
  parameter int NUM_SPLIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ELEM_W-1:0] in_src_a,
  input  logic [ELEM_W-1:0] in_src_b,
  input  logic [ELEM_W-1:0] in_acc,
  input  logic [1:0]        in_ediv,
  input  logic              in_signed,
  input  logic              in_vm,
  input  logic              in_mask,
  output logic              s1_valid,
  output logic              s1_upd,
  output logic [ELEM_W-1:0] s1_acc,
  output logic [ELEM_W-1:0] s1_dot
);

  logic [NUM_SPLIT-1:0][ELEM_W-1:0] dot_opt;
  logic [ELEM_W-1:0]                dot_sel;
  logic [1:0]                       sel_idx;

  // One dot unit per supported split width: 1, 2, 4, ... sub-elements
  for (genvar s = 0; s < NUM_SPLIT; s++) begin : g_split
    dp_split_dot #(
      .ELEM_W(ELEM_W),
      .NSUB  (1 << s)
    ) u_dot (
      .is_signed(in_signed),
      .src_a    (in_src_a),
      .src_b    (in_src_b),
      .dot      (dot_opt[s])
    );
  end

  always_comb begin
    sel_idx = split_index(in_ediv);
    dot_sel = dot_opt[sel_idx];
  end

  // Next-state values
  logic              valid_d;
  logic              upd_d;
  logic [ELEM_W-1:0] acc_d;
  logic [ELEM_W-1:0] dot_d;
  logic              data_en;

  always_comb begin
    data_en = in_valid;
    valid_d = in_valid;
    upd_d   = in_vm | in_mask;
    acc_d   = in_acc;
    dot_d   = dot_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_upd <= 1'b0;
      s1_acc <= '0;
      s1_dot <= '0;
    end else if (data_en) begin
      s1_upd <= upd_d;
      s1_acc <= acc_d;
      s1_dot <= dot_d;
    end
  end

endmodule

// File: rtl/dp_acc_stage.sv
module dp_acc_stage #(
  parameter int ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_upd,
  input  logic [ELEM_W-1:0] s1_acc,
  input  logic [ELEM_W-1:0] s1_dot,
  output logic              out_valid,
  output logic [ELEM_W-1:0] out_acc
);

  logic              valid_d;
  logic [ELEM_W-1:0] acc_d;
  logic              data_en;

  always_comb begin
    data_en = s1_valid;
    valid_d = s1_valid;
    acc_d   = s1_upd ? (s1_acc + s1_dot) : s1_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_acc <= '0;
    end else if (data_en) begin
      out_acc <= acc_d;
    end
  end

endmodule

// File: rtl/dp_lane.sv
module dp_lane #(
  parameter int ELEM_W    = 32,
  parameter int NUM_SPLIT = 3,
  parameter int RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ELEM_W-1:0] in_src_a,
  input  logic [ELEM_W-1:0] in_src_b,
  input  logic [ELEM_W-1:0] in_acc,
  input  logic [1:0]        in_ediv,
  input  logic              in_signed,
  input  logic              in_vm,
  input  logic              in_mask,
  output logic              out_valid,
  output logic [ELEM_W-1:0] out_acc
);

  logic              rst_n_sync;
  logic              s1_valid;
  logic              s1_upd;
  logic [ELEM_W-1:0] s1_acc;
  logic [ELEM_W-1:0] s1_dot;

  dp_rst_sync #(
    .STAGES(RST_SYNC)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  dp_prod_stage #(
    .ELEM_W   (ELEM_W),
    .NUM_SPLIT(NUM_SPLIT)
  ) u_prod (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_valid (in_valid),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .in_acc   (in_acc),
    .in_ediv  (in_ediv),
    .in_signed(in_signed),
    .in_vm    (in_vm),
    .in_mask  (in_mask),
    .s1_valid (s1_valid),
    .s1_upd   (s1_upd),
    .s1_acc   (s1_acc),
    .s1_dot   (s1_dot)
  );

  dp_acc_stage #(
    .ELEM_W(ELEM_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .s1_valid (s1_valid),
    .s1_upd   (s1_upd),
    .s1_acc   (s1_acc),
    .s1_dot   (s1_dot),
    .out_valid(out_valid),
    .out_acc  (out_acc)
  );

endmodule

// File: rtl/dp_lane_chk.sv
module dp_lane_chk #(
  parameter int ELEM_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ELEM_W-1:0] in_src_a,
  input logic [ELEM_W-1:0] in_src_b,
  input logic [ELEM_W-1:0] in_acc,
  input logic [1:0]        in_ediv,
  input logic              in_vm,
  input logic              in_mask,
  input logic              out_valid,
  input logic [ELEM_W-1:0] out_acc
);

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 $stable(out_acc));

  p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_vm && !in_mask) |=> ##1 (out_acc == $past(in_acc, 2)));

  p_whole_elem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vm && (in_ediv == 2'b00))
      |=> ##1 (out_acc == $past(ELEM_W'(in_acc + in_src_a * in_src_b), 2)));

endmodule

bind dp_lane dp_lane_chk #(.ELEM_W(ELEM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .in_valid (in_valid),
  .in_src_a (in_src_a),
  .in_src_b (in_src_b),
  .in_acc   (in_acc),
  .in_ediv  (in_ediv),
  .in_vm    (in_vm),
  .in_mask  (in_mask),
  .out_valid(out_valid),
  .out_acc  (out_acc)
);

// File: tb/dp_lane_tb.sv
module dp_lane_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 15;

  // Control field per vector: {ediv[1:0], signed, vm, mask}
  localparam logic [31:0] VA [NV] = '{
    32'h0000_0003, 32'hFFFF_FFFF, 32'h0002_0003, 32'hFFFF_0003, 32'hFFFF_0003,
    32'h0102_0304, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_0001,
    32'h0000_0003, 32'h0000_0003, 32'h0000_0002, 32'h0002_0003, 32'h8000_8000};
  localparam logic [31:0] VB [NV] = '{
    32'h0000_0005, 32'h0000_0002, 32'h0004_0005, 32'h0002_0005, 32'h0002_0005,
    32'h0506_0708, 32'h0101_0101, 32'h0101_0101, 32'h0001_0000, 32'h0000_0001,
    32'h0000_0003, 32'h0000_0003, 32'h0000_0002, 32'h0004_0005, 32'h8000_8000};
  localparam logic [31:0] VD [NV] = '{
    32'h0000_000A, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0064, 32'h0000_0064, 32'h0000_0005, 32'hFFFF_FFFF,
    32'h0000_1234, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam logic [4:0] VC [NV] = '{
    5'b00_0_1_0,  // R1 unsigned whole element
    5'b00_1_1_0,  // R1 signed select has no effect
    5'b01_0_1_0,  // R2 two halves
    5'b01_1_1_0,  // R4 signed halves
    5'b01_0_1_0,  // R4 same data unsigned
    5'b10_0_1_0,  // R3 four bytes
    5'b10_1_1_0,  // R4 signed bytes
    5'b10_0_1_0,  // R4 same bytes unsigned
    5'b00_0_1_0,  // R5 product wraps
    5'b00_0_1_0,  // R5 accumulate wraps
    5'b00_0_0_0,  // R6 masked off: pass through
    5'b00_0_0_1,  // R6 mask bit set: update
    5'b00_0_1_0,  // R6 mask ignored when vm=1
    5'b11_0_1_0,  // R9 reserved code acts as whole element
    5'b01_1_1_0}; // R5 signed halves sum to 2^31
  localparam logic [31:0] VX [NV] = '{
    32'h0000_0019, 32'hFFFF_FFFE, 32'h0000_0018, 32'h0000_000D, 32'h0002_000D,
    32'h0000_0046, 32'h0000_0060, 32'h0000_0460, 32'h0000_0005, 32'h0000_0000,
    32'h0000_1234, 32'h0000_000A, 32'h0000_0004, 32'h0016_000F, 32'h8000_0000};
  localparam int VR [NV] = '{1, 1, 2, 4, 4, 3, 4, 4, 5, 5, 6, 6, 6, 9, 5};

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_src_a;
  logic [31:0] in_src_b;
  logic [31:0] in_acc;
  logic [1:0]  in_ediv;
  logic        in_signed;
  logic        in_vm;
  logic        in_mask;
  logic        out_valid;
  logic [31:0] out_acc;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  dp_lane u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .in_acc   (in_acc),
    .in_ediv  (in_ediv),
    .in_signed(in_signed),
    .in_vm    (in_vm),
    .in_mask  (in_mask),
    .out_valid(out_valid),
    .out_acc  (out_acc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic [4:0] c);
    in_valid  = v;
    in_src_a  = a;
    in_src_b  = b;
    in_acc    = d;
    in_ediv   = c[4:3];
    in_signed = c[2];
    in_vm     = c[1];
    in_mask   = c[0];
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    drive(1'b0, '0, '0, '0, 5'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);

    // Vector walk: one element per cycle, result two edges later
    for (int j = 0; j < NV + 2; j++) begin
      if (j >= 2) begin
        check($sformatf("R%0d vector %0d result", VR[j-2], j-2), out_acc, VX[j-2]);
        check("R7 back-to-back valid", {31'd0, out_valid}, 32'd1);
      end
      if (j < NV) drive(1'b1, VA[j], VB[j], VD[j], VC[j]);
      else        drive(1'b0, '0, '0, '0, 5'b0);
      @(negedge clk);
    end
    check("R7 valid drops when idle", {31'd0, out_valid}, 32'd0);
    check("R7 output held when idle", out_acc, VX[NV-1]);

    // Single element latency
    drive(1'b1, 32'd7, 32'd6, 32'd1, 5'b10_0_1_0);  // R3: 7*6+1 in low byte
    @(negedge clk);
    drive(1'b0, '0, '0, '0, 5'b0);
    check("R7 not valid after one edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R7 valid after two edges", {31'd0, out_valid}, 32'd1);
    check("R3 single byte product", out_acc, 32'd43);
    @(negedge clk);
    check("R7 single pulse", {31'd0, out_valid}, 32'd0);

    // Reset with an element in flight
    drive(1'b1, 32'd2, 32'd2, 32'd0, 5'b00_0_1_0);
    @(negedge clk);
    drive(1'b0, '0, '0, '0, 5'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 in-flight element dropped", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 no result after reset", {31'd0, out_valid}, 32'd0);

    finish_run();
  end

endmodule